// File: doc/BRIEF.md
# MSI Write-Capture Interrupt Aggregator

This block receives message-signalled interrupts as posted memory writes into an address window. Each accepted write selects a slot (group and index register) from the address and a bit position from the write data, and sets that one pending bit. The array has 16 groups of 8 index registers, each 16 bits wide, for 2048 interrupt sources.

Every group derives a summary with one bit per index register that holds pending bits, and drives one level interrupt output. Software reads the summary to locate work, then reads the flagged index registers. A read of an index register returns its contents and clears them. If a new write lands in the same cycle, the new bit survives the clear. Malformed writes are dropped and raise a sticky error flag.

Top module: `msi_capture_agg`

## Requirements
- R1: A write with `in_valid` high, `in_addr[15:0]` zero, `in_addr[23]` zero and `in_data` below 16 sets bit `in_data[3:0]` of the index register selected by slot `in_addr[22:16]`, where group = slot[6:3] and index = slot[2:0]. The bit is pending from the clock edge that samples the write.
- R2: A write whose `in_addr[23]` is set, whose `in_addr[15:0]` is nonzero, or whose data is 16 or above changes no pending state. `wr_err` goes high at the edge that samples such a write and stays high until reset.
- R3: A read with `rd_en` high and `rd_addr = {1'b0, group[3:0], index[2:0], 16'h0000}` puts that index register on `rd_data` from the next clock edge for one cycle. `rd_data` is zero in cycles that follow no read.
- R4: A read of an index register clears it at the same edge that captures its old value.
- R5: A read at `rd_addr = {4'b1000, group[3:0], 16'h0000}` returns that group's summary in `rd_data[7:0]`, with bit n set while index register n holds any pending bit, and upper bits zero. Summary reads clear nothing.
- R6: `irq[g]` is high exactly while any index register of group g holds a pending bit. It rises after the setting write's edge and falls after the edge of the read that clears the last one.
- R7: If a valid write and an index read target the same register in one cycle, the read returns the old value and the written bit stays pending.
- R8: A read of any other offset returns zero and leaves all pending state unchanged.
- R9: Synchronous reset (`rst` high at a clock edge) clears all pending bits, `irq`, `rd_data` and `wr_err`.
- R10: Successive writes to the same register accumulate. Each one sets its bit without clearing the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound write strobe |
| in_addr | input | 24 | Inbound write offset within the window |
| in_data | input | 32 | Inbound write data (bit number) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read offset |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| irq | output | 16 | Per-group level interrupt outputs |
| wr_err | output | 1 | Sticky flag for dropped writes |

## Verification
Pending bits, `irq` and `wr_err` update at the edge that samples the write. `rd_data` and the clear caused by a read appear at the edge that samples `rd_en`, so every result is due one edge after its stimulus. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that produced the result. `rd_data` is sampled there before it returns to zero. The same-cycle collision is driven as a single cycle with both strobes, and a follow-up read checks the surviving bit.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

    localparam int unsigned N_GRP    = 16;
    localparam int unsigned N_IDX    = 8;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned ADDR_W   = 24;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SLOT_LSB = 16;

    localparam int unsigned GRP_W  = $clog2(N_GRP);
    localparam int unsigned IDX_W  = $clog2(N_IDX);
    localparam int unsigned BIT_W  = $clog2(REG_W);
    localparam int unsigned SLOT_W = GRP_W + IDX_W;
    localparam int unsigned SUM_BIT = ADDR_W - 1;

    typedef logic [REG_W-1:0] pend_reg_t;

    typedef struct packed {
        logic             hit;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
        logic [BIT_W-1:0] bitn;
    } set_req_t;

    typedef enum logic [1:0] {
        RD_NONE    = 2'd0,
        RD_INDEX   = 2'd1,
        RD_SUMMARY = 2'd2
    } rd_kind_t;

    typedef struct packed {
        rd_kind_t         kind;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
    } rd_req_t;

    function automatic logic data_in_range(input logic [DATA_W-1:0] d);
        return d < DATA_W'(REG_W);
    endfunction

    function automatic pend_reg_t bit_mask(input logic [BIT_W-1:0] b);
        return pend_reg_t'(1) << b;
    endfunction

endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
    import msi_agg_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output set_req_t          req,
    output logic              bad
);
    logic             addr_ok;
    logic             data_ok;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        addr_ok  = (addr[SLOT_LSB-1:0] == '0) &&
                   (addr[ADDR_W-1:SLOT_LSB+SLOT_W] == '0);
        data_ok  = data_in_range(data);
        slot     = addr[SLOT_LSB+SLOT_W-1:SLOT_LSB];
        req.hit  = valid && addr_ok && data_ok;
        req.grp  = slot[SLOT_W-1:IDX_W];
        req.idx  = slot[IDX_W-1:0];
        req.bitn = data[BIT_W-1:0];
        bad      = valid && !(addr_ok && data_ok);
    end
endmodule

// File: rtl/msi_rd_decode.sv
module msi_rd_decode
    import msi_agg_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output rd_req_t           req
);
    logic low_zero;

    always_comb begin
        low_zero = (addr[SLOT_LSB-1:0] == '0);
        req.kind = RD_NONE;
        req.grp  = '0;
        req.idx  = '0;
        if (en && low_zero) begin
            if (!addr[SUM_BIT]) begin
                req.kind = RD_INDEX;
                req.grp  = addr[SLOT_LSB+SLOT_W-1:SLOT_LSB+IDX_W];
                req.idx  = addr[SLOT_LSB+IDX_W-1:SLOT_LSB];
            end else if (addr[SUM_BIT-1:SLOT_LSB+GRP_W] == '0) begin
                req.kind = RD_SUMMARY;
                req.grp  = addr[SLOT_LSB+GRP_W-1:SLOT_LSB];
            end
        end
    end
endmodule

// File: rtl/msi_grp_bank.sv
module msi_grp_bank
    import msi_agg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_en,
    input  logic [IDX_W-1:0]              set_idx,
    input  logic [BIT_W-1:0]              set_bit,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [N_IDX-1:0][REG_W-1:0]   regs_o,
    output logic [N_IDX-1:0]              summary_o,
    output logic                          irq_o
);
    pend_reg_t pend_q [N_IDX];
    pend_reg_t pend_d [N_IDX];

    for (genvar i = 0; i < N_IDX; i++) begin : g_idx
        logic      hit_set;
        logic      hit_clr;
        pend_reg_t set_m;

        always_comb begin
            hit_set   = set_en && (set_idx == IDX_W'(i));
            hit_clr   = clr_en && (clr_idx == IDX_W'(i));
            set_m     = hit_set ? bit_mask(set_bit) : '0;
            // set wins over a same-cycle clear
            pend_d[i] = (hit_clr ? '0 : pend_q[i]) | set_m;
        end

        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= '0;
            else     pend_q[i] <= pend_d[i];
        end

        assign regs_o[i]    = pend_q[i];
        assign summary_o[i] = |pend_q[i];
    end

    assign irq_o = |summary_o;

    assert_set_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
        set_en |=> irq_o);

    assert_set_bit_lands_R1: assert property (@(posedge clk) disable iff (rst)
        set_en |=> regs_o[$past(set_idx)][$past(set_bit)]);

    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> (regs_o[$past(clr_idx)] == '0));

    assert_collision_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (set_en && clr_en && set_idx == clr_idx) |=> (regs_o[$past(set_idx)] != '0));
endmodule

// File: rtl/msi_capture_agg.sv
module msi_capture_agg
    import msi_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [N_GRP-1:0]  irq,
    output logic              wr_err
);
    set_req_t  wreq;
    logic      wbad;
    rd_req_t   rreq;
    pend_reg_t rd_value;

    logic [N_IDX-1:0][REG_W-1:0] bank_regs [N_GRP];
    logic [N_IDX-1:0]            bank_sum  [N_GRP];

    msi_wr_decode u_wdec (
        .valid (in_valid),
        .addr  (in_addr),
        .data  (in_data),
        .req   (wreq),
        .bad   (wbad)
    );

    msi_rd_decode u_rdec (
        .en   (rd_en),
        .addr (rd_addr),
        .req  (rreq)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic set_here;
        logic clr_here;

        assign set_here = wreq.hit && (wreq.grp == GRP_W'(g));
        assign clr_here = (rreq.kind == RD_INDEX) && (rreq.grp == GRP_W'(g));

        msi_grp_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .set_en    (set_here),
            .set_idx   (wreq.idx),
            .set_bit   (wreq.bitn),
            .clr_en    (clr_here),
            .clr_idx   (rreq.idx),
            .regs_o    (bank_regs[g]),
            .summary_o (bank_sum[g]),
            .irq_o     (irq[g])
        );
    end

    always_comb begin
        unique case (rreq.kind)
            RD_INDEX:   rd_value = bank_regs[rreq.grp][rreq.idx];
            RD_SUMMARY: rd_value = pend_reg_t'(bank_sum[rreq.grp]);
            default:    rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            wr_err  <= 1'b0;
        end else begin
            rd_data <= rd_value;
            if (wbad) wr_err <= 1'b1;
        end
    end

    assert_err_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err);

    assert_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_err) |-> $past(in_valid && !wreq.hit));

    assert_bad_write_dropped_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wreq.hit && !rd_en) |=> $stable(irq));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rreq.kind == RD_NONE) |=> (rd_data == '0));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));
endmodule

// File: tb/msi_capture_agg_bench.sv
module msi_capture_agg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] irq;
    logic        wr_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    msi_capture_agg u_msi_capture_agg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq      (irq),
        .wr_err   (wr_err)
    );

    typedef struct packed {
        logic        is_rd;
        logic [23:0] addr;
        logic [31:0] data;
        logic [15:0] exp_rd;
        logic [15:0] exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000000, 32'd5,  16'h0000, 16'h0001, 8'd1},  // R1 g0 i0 bit5
        '{1'b0, 24'h000000, 32'd9,  16'h0000, 16'h0001, 8'd10}, // R10 accumulate
        '{1'b1, 24'h800000, 32'd0,  16'h0001, 16'h0001, 8'd5},  // R5 summary g0
        '{1'b1, 24'h000000, 32'd0,  16'h0220, 16'h0000, 8'd3},  // R3 read, R6 irq drops
        '{1'b1, 24'h000000, 32'd0,  16'h0000, 16'h0000, 8'd4},  // R4 cleared
        '{1'b0, 24'h7F0000, 32'd15, 16'h0000, 16'h8000, 8'd1},  // R1 g15 i7 bit15
        '{1'b0, 24'h1A0000, 32'd0,  16'h0000, 16'h8008, 8'd6},  // R6 g3 i2 bit0
        '{1'b1, 24'h8F0000, 32'd0,  16'h0080, 16'h8008, 8'd5},  // R5 summary g15
        '{1'b1, 24'h830000, 32'd0,  16'h0004, 16'h8008, 8'd5},  // R5 summary g3
        '{1'b1, 24'h7F0000, 32'd0,  16'h8000, 16'h0008, 8'd4},  // R4 clear g15
        '{1'b1, 24'h1A0000, 32'd0,  16'h0001, 16'h0000, 8'd6},  // R6 all idle
        '{1'b1, 24'h900000, 32'd0,  16'h0000, 16'h0000, 8'd8},  // R8 unmapped
        '{1'b1, 24'h000004, 32'd0,  16'h0000, 16'h0000, 8'd8}   // R8 unmapped
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9", "irq after reset", 32'(irq), 32'h0);
        check("R9", "wr_err after reset", 32'(wr_err), 32'h0);
        check("R9", "rd_data after reset", 32'(rd_data), 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_rd) begin
                rd(VECS[k].addr, v);
                check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d rd_data", k),
                      32'(v), 32'(VECS[k].exp_rd));
            end else begin
                wr(VECS[k].addr, VECS[k].data);
            end
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d irq", k),
                  32'(irq), 32'(VECS[k].exp_irq));
        end

        // R3 rd_data returns to zero after a read
        @(negedge clk);
        check("R3", "rd_data idle", 32'(rd_data), 32'h0);

        // R2 malformed writes
        check("R2", "wr_err before bad write", 32'(wr_err), 32'h0);
        wr(24'h000000, 32'd16);
        check("R2", "irq after data>=16", 32'(irq), 32'h0);
        check("R2", "wr_err set", 32'(wr_err), 32'h1);
        wr(24'h800000, 32'd1);
        wr(24'h000001, 32'd3);
        check("R2", "irq after bad addr", 32'(irq), 32'h0);
        rd(24'h000000, v);
        check("R2", "nothing set by bad writes", 32'(v), 32'h0);
        wr(24'h080000, 32'd1);
        check("R2", "wr_err sticky", 32'(wr_err), 32'h1);

        // R7 collision on g1 i0 (holds bit1)
        @(negedge clk);
        in_valid = 1'b1; in_addr = 24'h080000; in_data = 32'd2;
        rd_en = 1'b1; rd_addr = 24'h080000;
        @(negedge clk);
        v = rd_data;
        in_valid = 1'b0; rd_en = 1'b0;
        check("R7", "collision returns old", 32'(v), 32'h0002);
        check("R7", "irq kept", 32'(irq), 32'h0002);
        rd(24'h080000, v);
        check("R7", "new bit survived", 32'(v), 32'h0004);

        // R8 unmapped reads leave state; R5 summary read clears nothing
        wr(24'h100000, 32'd4);
        rd(24'h100008, v);
        check("R8", "low-bit offset", 32'(v), 32'h0);
        rd(24'hA00000, v);
        check("R8", "high offset", 32'(v), 32'h0);
        rd(24'h820000, v);
        check("R5", "summary g2 first", 32'(v), 32'h0001);
        rd(24'h820000, v);
        check("R5", "summary g2 again", 32'(v), 32'h0001);
        rd(24'h100000, v);
        check("R8", "pending intact", 32'(v), 32'h0010);

        // R9 mid-run reset
        wr(24'h300000, 32'd7);
        check("R6", "irq g6 up", 32'(irq), 32'h0040);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9", "irq cleared by reset", 32'(irq), 32'h0);
        check("R9", "wr_err cleared by reset", 32'(wr_err), 32'h0);
        rd(24'h300000, v);
        check("R9", "pending cleared by reset", 32'(v), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule